// File: doc/BRIEF.md
# Configurable Output Macrocell Bank

This block is the output stage that sits between a sum-of-products logic array and the device pins. Each cell receives one OR-sum and one output-enable product term from the array. It produces the data and enable for a tristate pad, and it returns a feedback bit to the array. The bank holds `NCELL` identical cells. Every cell has its own two configuration bits: a path bit picks registered or combinational operation, and a polarity bit picks active-high or inverted output.

Each cell holds a rising-edge D flip-flop. The flip-flops share a global asynchronous clear, which is driven by either the general reset input or a power-on reset input. They also share a synchronous preset and a synchronous test preload, which forces a chosen value into every register. In registered mode the feedback to the array is the complement of the flip-flop. In combinational mode the feedback is the value seen on the pad, so a cell whose enable term is held false works as a dedicated input.

The configuration bits follow erased-cell semantics. An erased bit reads 1 and selects the "1" path of its multiplexer, and a programmed bit reads 0. All ports are plain control and data pins. There is no handshake and no back-pressure, because every output is valid in every cycle.

Top module: `pld_out_cell`

## Requirements
- R1: `cfg_path[i]`=0 drives the cell's pad data from its flip-flop. `cfg_path[i]`=1 bypasses the flip-flop, so the pad data follows `sum_in[i]` in the same cycle.
- R2: `cfg_pol[i]`=1 gives active-high output and `cfg_pol[i]`=0 inverts the pad data, in both registered and combinational mode.
- R3: On each rising clock edge with no reset, preset or preload active, the flip-flop captures `sum_in[i]`.
- R4: In registered mode, `fb_out[i]` is the complement of the flip-flop, whatever the polarity bit is.
- R5: In combinational mode, `fb_out[i]` equals `pin_in[i]`, including while the driver is off.
- R6: `pin_oe[i]` follows `oe_term[i]` in every cycle. Holding it at 0 leaves the pad undriven, so it is input-only.
- R7: `arst` or `por` clears every flip-flop at once, without waiting for a clock edge, and overrides preset and preload.
- R8: `preset` sets every flip-flop to 1 at the next rising edge and takes priority over preload.
- R9: `preload_en` with `preset` low loads `preload_data` into the flip-flops at the next rising edge.
- R10: An erased cell (both configuration bits 1) acts as a combinational, active-high output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock, rising edge |
| arst | input | 1 | Global asynchronous clear, active high |
| por | input | 1 | Power-on reset, asynchronous clear, active high |
| preset | input | 1 | Synchronous set of all registers |
| preload_en | input | 1 | Synchronous test load enable |
| preload_data | input | NCELL | Test value loaded into the registers |
| cfg_path | input | NCELL | Per cell: 0 registered, 1 combinational |
| cfg_pol | input | NCELL | Per cell: 1 active-high, 0 inverted |
| sum_in | input | NCELL | OR-sum from the array |
| oe_term | input | NCELL | Output-enable product term |
| pin_in | input | NCELL | Value currently seen on the pad |
| pin_data | output | NCELL | Data driven toward the pad |
| pin_oe | output | NCELL | Pad driver enable |
| fb_out | output | NCELL | Feedback to the array |

## Verification
The hardest case to reach is a clear that arrives between clock edges while preset is already raised. The register must drop at once and then stay low through the following edge, even though preset asks for a set. The stimulus raises `arst` one nanosecond after a falling edge with `preset` held high. It samples the registered pads before the next rising edge and again after it. The behavioural model runs across the whole sequence, so the preload and preset priority around it is compared on every clock as well.

// File: rtl/pld_out_cell_pkg.sv
package pld_out_cell_pkg;
  typedef enum logic {
    PATH_REG  = 1'b0,
    PATH_COMB = 1'b1
  } path_e;

  typedef enum logic {
    POL_LOW  = 1'b0,
    POL_HIGH = 1'b1
  } pol_e;

  typedef struct packed {
    path_e path;
    pol_e  pol;
  } cell_cfg_t;
endpackage

// File: rtl/pld_cell_flop.sv
module pld_cell_flop (
  input  logic clk,
  input  logic clr,
  input  logic set_sync,
  input  logic load_en,
  input  logic load_val,
  input  logic d,
  output logic q
);
  // clear is asynchronous and dominant; then preset, then preload, then data
  always_ff @(posedge clk or posedge clr) begin
    if (clr)           q <= 1'b0;
    else if (set_sync) q <= 1'b1;
    else if (load_en)  q <= load_val;
    else               q <= d;
  end
endmodule

// File: rtl/pld_cell_route.sv
module pld_cell_route
  import pld_out_cell_pkg::*;
(
  input  cell_cfg_t cfg,
  input  logic      q,
  input  logic      sum,
  input  logic      pad_val,
  output logic      data_o,
  output logic      fb_o
);
  logic core;

  always_comb begin
    core   = (cfg.path == PATH_COMB) ? sum : q;
    data_o = (cfg.pol == POL_HIGH) ? core : ~core;
    fb_o   = (cfg.path == PATH_COMB) ? pad_val : ~q;
  end
endmodule

// File: rtl/pld_out_cell.sv
module pld_out_cell
  import pld_out_cell_pkg::*;
#(
  parameter int NCELL = 4
) (
  input  logic             clk,
  input  logic             arst,
  input  logic             por,
  input  logic             preset,
  input  logic             preload_en,
  input  logic [NCELL-1:0] preload_data,
  input  logic [NCELL-1:0] cfg_path,
  input  logic [NCELL-1:0] cfg_pol,
  input  logic [NCELL-1:0] sum_in,
  input  logic [NCELL-1:0] oe_term,
  input  logic [NCELL-1:0] pin_in,
  output logic [NCELL-1:0] pin_data,
  output logic [NCELL-1:0] pin_oe,
  output logic [NCELL-1:0] fb_out
);
  logic             clr_all;
  logic [NCELL-1:0] flop_q;

  assign clr_all = arst | por;

  for (genvar i = 0; i < NCELL; i++) begin : g_cell
    cell_cfg_t cfg_i;
    assign cfg_i.path = path_e'(cfg_path[i]);
    assign cfg_i.pol  = pol_e'(cfg_pol[i]);

    pld_cell_flop u_flop (
      .clk      (clk),
      .clr      (clr_all),
      .set_sync (preset),
      .load_en  (preload_en),
      .load_val (preload_data[i]),
      .d        (sum_in[i]),
      .q        (flop_q[i])
    );

    pld_cell_route u_route (
      .cfg     (cfg_i),
      .q       (flop_q[i]),
      .sum     (sum_in[i]),
      .pad_val (pin_in[i]),
      .data_o  (pin_data[i]),
      .fb_o    (fb_out[i])
    );

    assign pin_oe[i] = oe_term[i];
  end
endmodule

// File: rtl/pld_out_cell_chk.sv
module pld_out_cell_chk #(
  parameter int NCELL = 4
) (
  input logic             clk,
  input logic             arst,
  input logic             por,
  input logic             preset,
  input logic             preload_en,
  input logic [NCELL-1:0] preload_data,
  input logic [NCELL-1:0] cfg_path,
  input logic [NCELL-1:0] cfg_pol,
  input logic [NCELL-1:0] sum_in,
  input logic [NCELL-1:0] pin_in,
  input logic [NCELL-1:0] pin_data,
  input logic [NCELL-1:0] fb_out,
  input logic [NCELL-1:0] flop_q
);
  logic rst_any;
  assign rst_any = arst | por;

  // R7
  reset_clears_chk: assert property (@(posedge clk) disable iff (rst_any)
    $fell(rst_any) |-> flop_q == '0);

  // R8
  preset_sets_chk: assert property (@(posedge clk) disable iff (rst_any)
    preset |=> &flop_q);

  // R9
  preload_loads_chk: assert property (@(posedge clk) disable iff (rst_any)
    (!preset && preload_en) |=> flop_q == $past(preload_data));

  for (genvar i = 0; i < NCELL; i++) begin : g_chk
    // R3
    capture_chk: assert property (@(posedge clk) disable iff (rst_any)
      (!preset && !preload_en) |=> flop_q[i] == $past(sum_in[i]));

    // R4
    reg_feedback_chk: assert property (@(posedge clk) disable iff (rst_any)
      !cfg_path[i] |-> fb_out[i] == ~flop_q[i]);

    // R5
    comb_feedback_chk: assert property (@(posedge clk) disable iff (rst_any)
      cfg_path[i] |-> fb_out[i] == pin_in[i]);

    // R2
    reg_polarity_chk: assert property (@(posedge clk) disable iff (rst_any)
      (!cfg_path[i] && cfg_pol[i]) |-> pin_data[i] == flop_q[i]);
  end
endmodule

bind pld_out_cell pld_out_cell_chk #(.NCELL(NCELL)) chk_i (
  .clk          (clk),
  .arst         (arst),
  .por          (por),
  .preset       (preset),
  .preload_en   (preload_en),
  .preload_data (preload_data),
  .cfg_path     (cfg_path),
  .cfg_pol      (cfg_pol),
  .sum_in       (sum_in),
  .pin_in       (pin_in),
  .pin_data     (pin_data),
  .fb_out       (fb_out),
  .flop_q       (flop_q)
);

// File: tb/pld_out_cell_tb_top.sv
module pld_out_cell_tb_top;
  localparam int NCELL = 4;

  logic             clk = 1'b0;
  logic             arst = 1'b0;
  logic             por = 1'b1;
  logic             preset = 1'b0;
  logic             preload_en = 1'b0;
  logic [NCELL-1:0] preload_data = '0;
  logic [NCELL-1:0] cfg_path = '1;
  logic [NCELL-1:0] cfg_pol = '1;
  logic [NCELL-1:0] sum_in = '0;
  logic [NCELL-1:0] oe_term = '0;
  logic [NCELL-1:0] pin_in = '0;
  logic [NCELL-1:0] pin_data, pin_oe, fb_out;

  int n_chk = 0;
  int n_fail = 0;
  logic [NCELL-1:0] mq;
  logic rst_m;

  always #4 clk = ~clk;

  pld_out_cell #(.NCELL(NCELL)) dut_i (
    .clk(clk), .arst(arst), .por(por), .preset(preset),
    .preload_en(preload_en), .preload_data(preload_data),
    .cfg_path(cfg_path), .cfg_pol(cfg_pol), .sum_in(sum_in),
    .oe_term(oe_term), .pin_in(pin_in), .pin_data(pin_data),
    .pin_oe(pin_oe), .fb_out(fb_out)
  );

  // behavioural reference register, written from R3, R7, R8, R9
  assign rst_m = arst | por;
  always @(posedge clk or posedge rst_m) begin
    if (rst_m) mq <= '0;
    else begin
      for (int i = 0; i < NCELL; i++) begin
        if (preset) mq[i] <= 1'b1;
        else if (preload_en) mq[i] <= preload_data[i];
        else mq[i] <= sum_in[i];
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic exp_data(int i);
    logic v;
    if (cfg_path[i]) v = sum_in[i];
    else v = mq[i];
    if (!cfg_pol[i]) v = !v;
    return v;
  endfunction

  function automatic logic exp_fb(int i);
    if (cfg_path[i]) return pin_in[i];
    return !mq[i];
  endfunction

  task automatic compare_all();
    for (int i = 0; i < NCELL; i++) begin
      chk("R1 R2 R3 pin_data", 32'(pin_data[i]), 32'(exp_data(i)));
      chk("R6 pin_oe", 32'(pin_oe[i]), 32'(oe_term[i]));
      chk("R4 R5 fb_out", 32'(fb_out[i]), 32'(exp_fb(i)));
    end
  endtask

  task automatic step_rand(input bit rand_cfg, input bit rand_ctl);
    @(negedge clk);
    sum_in  = NCELL'($urandom);
    oe_term = NCELL'($urandom);
    pin_in  = NCELL'($urandom);
    if (rand_cfg) begin
      cfg_path = NCELL'($urandom);
      cfg_pol  = NCELL'($urandom);
    end
    if (rand_ctl) begin
      preset       = ($urandom % 8) == 0;
      preload_en   = ($urandom % 6) == 0;
      preload_data = NCELL'($urandom);
    end
    #3 compare_all();
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    // R10: erased configuration, combinational active-high
    sum_in = 4'b1010; pin_in = 4'b0110; oe_term = 4'b1100;
    #3;
    chk("R10 erased pin_data", 32'(pin_data), 32'(4'b1010));
    chk("R10 erased fb_out", 32'(fb_out), 32'(4'b0110));
    // R7: reset state in registered mode
    cfg_path = 4'b0000; cfg_pol = 4'b1111;
    #1;
    chk("R7 reset pin_data", 32'(pin_data), 32'(4'b0000));
    chk("R7 reset fb_out", 32'(fb_out), 32'(4'b1111));
    @(negedge clk); @(negedge clk);
    #2 por = 1'b0;

    // fixed mix: cell0 reg/high, cell1 reg/low, cell2 comb/high, cell3 comb/low
    cfg_path = 4'b1100; cfg_pol = 4'b0101;
    for (int k = 0; k < 40; k++) step_rand(1'b0, 1'b0);

    // R8: preset dominates preload
    @(negedge clk);
    cfg_path = 4'b0000; cfg_pol = 4'b1111;
    preset = 1'b1; preload_en = 1'b1; preload_data = 4'b0000;
    @(negedge clk);
    preset = 1'b0; preload_en = 1'b0;
    #1 chk("R8 preset over preload", 32'(pin_data), 32'(4'b1111));

    // R9: preload
    @(negedge clk);
    preload_en = 1'b1; preload_data = 4'b0110; sum_in = 4'b1001;
    @(negedge clk);
    preload_en = 1'b0;
    #1 chk("R9 preload value", 32'(pin_data), 32'(4'b0110));
    chk("R4 fb after preload", 32'(fb_out), 32'(4'b1001));

    // R3: capture with inverted polarity
    @(negedge clk);
    sum_in = 4'b0011; cfg_pol = 4'b0000;
    @(negedge clk);
    #1 chk("R3 R2 capture inverted", 32'(pin_data), 32'(4'b1100));
    chk("R4 fb independent of polarity", 32'(fb_out), 32'(4'b1100));

    // R7: mid-cycle clear with preset held across the edge
    @(negedge clk);
    cfg_pol = 4'b1111; preset = 1'b1;
    @(negedge clk);
    chk("R8 preset before clear", 32'(pin_data), 32'(4'b1111));
    #1 arst = 1'b1;
    #1 chk("R7 async clear", 32'(pin_data), 32'(4'b0000));
    @(negedge clk);
    #1 chk("R7 clear over preset", 32'(pin_data), 32'(4'b0000));
    preset = 1'b0;
    #1 arst = 1'b0;

    // R5 R6: pin as dedicated input
    @(negedge clk);
    cfg_path = 4'b1111; oe_term = 4'b0000; pin_in = 4'b1011; sum_in = 4'b0000;
    #1 chk("R6 driver off", 32'(pin_oe), 32'(4'b0000));
    chk("R5 pad feedback", 32'(fb_out), 32'(4'b1011));
    @(negedge clk);
    pin_in = 4'b0100;
    #1 chk("R5 pad feedback change", 32'(fb_out), 32'(4'b0100));

    // R1: combinational follows in the same cycle
    @(negedge clk);
    sum_in = 4'b0101; cfg_pol = 4'b1111;
    #1 chk("R1 bypass same cycle", 32'(pin_data), 32'(4'b0101));

    // broad random run
    for (int k = 0; k < 300; k++) step_rand(1'b1, 1'b1);
    @(negedge clk);
    preset = 1'b0; preload_en = 1'b0;
    step_rand(1'b0, 1'b0);
    report();
  end
endmodule